// File: doc/BRIEF.md
# Bidirectional Memory Data Buffer

This block is a single 32-bit holding register that sits between a processor's one shared internal bus and the external memory/peripheral data bus. It carries traffic both ways. On a load from memory it captures the external bus and later hands the word to the internal bus. On a store it captures the internal bus and later presents the word to the external bus.

A source-select input picks which bus the register captures from when its write strobe is high at a rising clock edge. Two independent read enables each switch on one output driver. One driver feeds the internal bus and the other feeds the external bus.

Each driver is modelled as a data port plus an output-enable port. While the enable is low, the driver is released and its data port reads zero. Tying the pair to a tri-state pad or to a bus multiplexer is left to the surrounding logic.

A combinational flag warns when a write is requested while the register is also driving the same bus it is loading from.

Top module: `mem_data_buffer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the stored word to 0.
- R2: With wr=1 and src_ext=1 at a rising edge, the stored word becomes the value on ext_in.
- R3: With wr=1 and src_ext=0 at a rising edge, the stored word becomes the value on int_in.
- R4: With wr=0, the stored word keeps its value whatever ext_in, int_in and src_ext do.
- R5: rd_int=1 sets int_oe=1 and puts the stored word on int_out. When rd_int=0, int_oe=0 and int_out=0.
- R6: rd_ext=1 sets ext_oe=1 and puts the stored word on ext_out. When rd_ext=0, ext_oe=0 and ext_out=0.
- R7: With rd_int=1 and rd_ext=1 together, both sides are enabled and both carry the stored word.
- R8: conflict=1 exactly when wr=1 and the driver toward the selected source bus is enabled: either src_ext=1 with rd_ext=1, or src_ext=0 with rd_int=1. The write still takes place.
- R9: A read in the same cycle as a write shows the word stored before that edge. The new word appears only after the edge.
- R10: While rst is high, both drivers are released (int_oe=0, ext_oe=0, both data ports 0) regardless of the read enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ext | input | 1 | Load source: 1 selects the external bus, 0 the internal bus |
| wr | input | 1 | Capture the selected source at the next rising edge |
| rd_int | input | 1 | Drive the stored word toward the internal bus |
| rd_ext | input | 1 | Drive the stored word toward the external bus |
| ext_in | input | DW | Value present on the external data bus |
| int_in | input | DW | Value present on the internal CPU bus |
| ext_out | output | DW | Word driven toward the external bus, 0 when released |
| ext_oe | output | 1 | External driver enable |
| int_out | output | DW | Word driven toward the internal bus, 0 when released |
| int_oe | output | 1 | Internal driver enable |
| conflict | output | 1 | Write requested while driving the bus being loaded from |

## Verification
The bench loads distinct words from each side with the opposite bus carrying a decoy. A design with the select sense inverted would store the decoy.

It holds wr low while both input buses toggle. A register that captures without the strobe would change its word.

Within one cycle, the bench reads alongside a write and checks that the old word shows before the edge and the new one after. A design that drives its input straight through would show the new word too early.

It also asserts reset with both read enables high, drives both enables together, and tries all four conflict combinations. These catch drivers that stay on through reset, an exclusive-or between the two sides, and a flag keyed to the wrong bus.

// File: rtl/mem_data_buffer.sv
module mem_data_buffer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          src_ext,
  input  logic          wr,
  input  logic          rd_int,
  input  logic          rd_ext,
  input  logic [DW-1:0] ext_in,
  input  logic [DW-1:0] int_in,
  output logic [DW-1:0] ext_out,
  output logic          ext_oe,
  output logic [DW-1:0] int_out,
  output logic          int_oe,
  output logic          conflict
);

  logic [DW-1:0] word_q;
  logic [DW-1:0] load_val;

  assign load_val = src_ext ? ext_in : int_in;

  always_ff @(posedge clk) begin
    if (rst)
      word_q <= '0;
    else if (wr)
      word_q <= load_val;
  end

  assign int_oe   = rd_int & ~rst;
  assign ext_oe   = rd_ext & ~rst;
  assign int_out  = int_oe ? word_q : '0;
  assign ext_out  = ext_oe ? word_q : '0;
  assign conflict = wr & (src_ext ? rd_ext : rd_int);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (word_q == '0));

  assert_load_ext_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && src_ext) |=> (word_q == $past(ext_in)));

  assert_load_int_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && !src_ext) |=> (word_q == $past(int_in)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(word_q));

  assert_drivers_released_R10: assert property (@(posedge clk)
    rst |-> (!int_oe && !ext_oe && int_out == '0 && ext_out == '0));

endmodule

// File: tb/sim_mem_data_buffer.sv
module sim_mem_data_buffer;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst, src_ext, wr, rd_int, rd_ext;
  logic [DW-1:0] ext_in, int_in, ext_out, int_out;
  logic          ext_oe, int_oe, conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mem_data_buffer #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .src_ext(src_ext), .wr(wr), .rd_int(rd_int),
    .rd_ext(rd_ext), .ext_in(ext_in), .int_in(int_in), .ext_out(ext_out),
    .ext_oe(ext_oe), .int_out(int_out), .int_oe(int_oe), .conflict(conflict)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rst = 0; wr = 0; rd_int = 0; rd_ext = 0; src_ext = 0;
    #1;
  endtask

  task automatic load(input logic sel, input logic [DW-1:0] ev, input logic [DW-1:0] iv);
    @(negedge clk);
    src_ext = sel; wr = 1; rd_int = 0; rd_ext = 0; ext_in = ev; int_in = iv;
    @(negedge clk);
    wr = 0; ext_in = ~ev; int_in = ~iv;
  endtask

  task automatic peek_int(input string tag, input logic [DW-1:0] exp);
    @(negedge clk);
    wr = 0; rd_int = 1; rd_ext = 0; #1;
    chk({tag, " int_oe"}, {31'b0, int_oe}, 1);
    chk({tag, " int_out"}, int_out, exp);
    rd_int = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; rd_int = 1; rd_ext = 1; wr = 0; #1;
    chk("R10 int_oe in reset", {31'b0, int_oe}, 0);
    chk("R10 ext_oe in reset", {31'b0, ext_oe}, 0);
    chk("R10 int_out in reset", int_out, 0);
    chk("R10 ext_out in reset", ext_out, 0);
    idle();
    peek_int("R1 cleared", 0);
  endtask

  task automatic t_load_ext();
    load(1, 32'hA5A5_1234, 32'hDEAD_BEEF);
    peek_int("R2 ext load", 32'hA5A5_1234);
  endtask

  task automatic t_load_int();
    load(0, 32'h1111_2222, 32'h7E57_C0DE);
    peek_int("R3 int load", 32'h7E57_C0DE);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr = 0; src_ext = i[0]; ext_in = 32'h0F0F_0000 + i; int_in = 32'hF0F0_0000 + i;
    end
    peek_int("R4 hold", 32'h7E57_C0DE);
  endtask

  task automatic t_drivers();
    @(negedge clk);
    rd_int = 0; rd_ext = 0; #1;
    chk("R5 int released", {int_oe, int_out[30:0]}, 0);
    chk("R6 ext released", {ext_oe, ext_out[30:0]}, 0);
    rd_ext = 1; #1;
    chk("R6 ext_oe", {31'b0, ext_oe}, 1);
    chk("R6 ext_out", ext_out, 32'h7E57_C0DE);
    chk("R5 int idle while ext reads", {31'b0, int_oe}, 0);
    rd_int = 1; #1;
    chk("R7 both int", int_out, 32'h7E57_C0DE);
    chk("R7 both ext", ext_out, 32'h7E57_C0DE);
    chk("R7 both oe", {30'b0, int_oe, ext_oe}, 3);
    rd_int = 0; rd_ext = 0;
  endtask

  task automatic t_conflict();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr = i[2]; src_ext = i[1]; rd_ext = i[0]; rd_int = ~i[0]; #1;
      chk("R8 conflict", {31'b0, conflict}, {31'b0, i[2] & (i[1] ? i[0] : ~i[0])});
    end
    idle();
  endtask

  task automatic t_read_during_write();
    @(negedge clk);
    src_ext = 1; wr = 1; rd_int = 1; ext_in = 32'hCAFE_0001; #1;
    chk("R9 old word before edge", int_out, 32'hCAFE_0000);
    @(posedge clk); #1;
    wr = 0;
    chk("R9 new word after edge", int_out, 32'hCAFE_0001);
    idle();
  endtask

  initial begin
    rst = 1; wr = 0; rd_int = 0; rd_ext = 0; src_ext = 0; ext_in = 0; int_in = 0;
    repeat (2) @(posedge clk);
    idle();
    load(0, 0, 32'h5555_AAAA);
    t_reset();
    t_load_ext();
    t_load_int();
    t_hold();
    t_drivers();
    t_conflict();
    load(1, 32'hCAFE_0000, 0);
    t_read_during_write();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule